// File: doc/BRIEF.md
# Output Channel Fault Latch-Off Controller With Blanking

This block guards a bank of switched power outputs. Each channel holds one drive-enable bit, loaded as a group when a frame enable input rises. Each channel also has a comparator input that goes high when that output's voltage sits above its saturation threshold. When a channel is commanded on but its output stays high, the load is pulling too much current, and the controller latches that channel off. It stays off until the next group load.

Switching a load on draws a large surge current. To let the output settle, every group load starts a blanking window of a fixed number of clock cycles. During that window no fault can clear a channel. A new rising edge of the frame enable restarts the window from the beginning. Fault clearing is allowed only once the window has expired and while the frame enable is held high. The block also returns the synchronised comparator level of every channel, so a serial status path can capture it. That level is high when the output is high, whether the channel was commanded off or latched off. An open-circuit output reads low, because its pull-down holds it low.

Top module: `outsw_guard`

## Requirements
- R1: A clock edge with `rst` high sets every bit of `drive_en_o` to 0 (all channels off) and leaves the blanking window expired.
- R2: On a clock edge where `frame_en_i` is 1 and was 0 at the previous edge (a commit), `drive_en_o` takes the value of `cmd_i` in the following cycle. Bit i controls channel i, and 1 means on.
- R3: Fault clearing is blocked for the BLANK_CYCLES edges that follow a commit edge. From the next edge onward, each such edge clears every bit of `drive_en_o` whose `sense_o` bit is 1.
- R4: While `frame_en_i` is 0, `drive_en_o` holds its value, even when enabled channels report a high sense level.
- R5: Apart from a commit, no channel ever turns on. A channel cleared by a fault stays off after its sense level drops. A change of `cmd_i` without a commit has no effect.
- R6: `sense_o` equals `sense_i` delayed by exactly two clock cycles, for every channel, whatever its command.
- R7: A commit that occurs inside a running blanking window restarts the full window of BLANK_CYCLES edges from that commit.
- R8: A fault clears only the channel whose sense bit is high. The other enabled channels stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_en_i | input | 1 | Frame enable; its rising edge commits `cmd_i`, and its high level arms fault clearing |
| cmd_i | input | NCH | Command bits, 1 = channel on |
| sense_i | input | NCH | Asynchronous comparator outputs, 1 = output above saturation threshold |
| drive_en_o | output | NCH | Registered effective drive enables |
| sense_o | output | NCH | Synchronised sense levels for status capture |

## Verification
The hardest case to reach is a fault that arrives inside a blanking window that was retriggered before it expired. Only the second window may then decide when the channel drops. The bench commits, drops the frame enable for one cycle partway through the window, and commits again with the fault already present. It then checks that the channel is still on past the point where the first window would have ended, and that it drops exactly one edge after the second window ends. A second hard case is a fault whose window has expired while the frame enable is low. Here the stimulus lowers the frame enable right after a commit and waits out the window before raising the sense level.

// File: rtl/outsw_pkg.sv
package outsw_pkg;
  localparam int unsigned DEF_NCH   = 8;
  localparam int unsigned DEF_BLANK = 2000;

  // Operation applied to every channel latch on a clock edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_TRIM = 2'd2
  } latch_op_e;
endpackage

// File: rtl/outsw_sync.sv
module outsw_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // Two-stage synchroniser, left without reset so no reset fan-out lands on it
  always_ff @(posedge clk) begin
    meta_q <= d_i;
    sync_q <= meta_q;
  end

  assign q_o = sync_q;
endmodule

// File: rtl/outsw_blank_timer.sv
module outsw_blank_timer #(
  parameter int unsigned BLANK_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic armed_o
);
  localparam int unsigned RAW_W = $clog2(BLANK_CYCLES + 1);
  localparam int unsigned CW    = (RAW_W < 1) ? 1 : RAW_W;
  localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign armed_o = (cnt_q == '0);
endmodule

// File: rtl/outsw_chan.sv
module outsw_chan
  import outsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  latch_op_e op_i,
  input  logic      cmd_i,
  input  logic      sense_i,
  output logic      on_o
);
  logic on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q <= 1'b0;
    end else begin
      unique case (op_i)
        OP_LOAD: on_q <= cmd_i;
        OP_TRIM: if (sense_i) on_q <= 1'b0;
        default: on_q <= on_q;
      endcase
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/outsw_guard.sv
module outsw_guard
  import outsw_pkg::*;
#(
  parameter int unsigned NCH          = DEF_NCH,
  parameter int unsigned BLANK_CYCLES = DEF_BLANK
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_en_i,
  input  logic [NCH-1:0] cmd_i,
  input  logic [NCH-1:0] sense_i,
  output logic [NCH-1:0] drive_en_o,
  output logic [NCH-1:0] sense_o
);
  logic           frame_q;
  logic           commit;
  logic           armed;
  latch_op_e      op;
  logic [NCH-1:0] sense_s;

  // Previous frame level for edge detection
  always_ff @(posedge clk) begin
    frame_q <= frame_en_i;
  end

  assign commit = frame_en_i & ~frame_q;

  outsw_sync #(.W(NCH)) u_sync (
    .clk (clk),
    .d_i (sense_i),
    .q_o (sense_s)
  );

  outsw_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (commit),
    .armed_o (armed)
  );

  always_comb begin
    if (commit)                  op = OP_LOAD;
    else if (frame_en_i && armed) op = OP_TRIM;
    else                         op = OP_HOLD;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    outsw_chan u_ch (
      .clk     (clk),
      .rst     (rst),
      .op_i    (op),
      .cmd_i   (cmd_i[g]),
      .sense_i (sense_s[g]),
      .on_o    (drive_en_o[g])
    );
  end

  assign sense_o = sense_s;
endmodule

// File: rtl/outsw_guard_chk.sv
module outsw_guard_chk #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned BLANK = 2000
) (
  input logic           clk,
  input logic           rst,
  input logic           frame_en_i,
  input logic [NCH-1:0] cmd_i,
  input logic [NCH-1:0] sense_i,
  input logic [NCH-1:0] drive_en_o,
  input logic [NCH-1:0] sense_o
);
  localparam int unsigned RAW_W = $clog2(BLANK + 1);
  localparam int unsigned SW    = (RAW_W < 1) ? 1 : RAW_W;
  localparam logic [SW-1:0] SAT = SW'(BLANK);

  logic          prev_frame;
  logic          rise;
  logic [SW-1:0] since;

  always_ff @(posedge clk) prev_frame <= frame_en_i;
  assign rise = frame_en_i & ~prev_frame;

  // Edges elapsed since the last commit, saturating at BLANK
  always_ff @(posedge clk) begin
    if (rst)             since <= SAT;
    else if (rise)       since <= '0;
    else if (since < SAT) since <= since + 1'b1;
  end

  assert_reset_off_R1: assert property (@(posedge clk)
    rst |=> drive_en_o == '0);

  assert_commit_load_R2: assert property (@(posedge clk) disable iff (rst)
    rise |=> drive_en_o == $past(cmd_i));

  assert_blank_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!rise && since < SAT) |=> drive_en_o == $past(drive_en_o));

  assert_fault_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_en_i && !rise && since == SAT) |=>
      drive_en_o == ($past(drive_en_o) & ~$past(sense_o)));

  assert_frame_low_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_en_i |=> drive_en_o == $past(drive_en_o));

  assert_no_turn_on_R5: assert property (@(posedge clk) disable iff (rst)
    !rise |=> (drive_en_o & ~$past(drive_en_o)) == '0);

  assert_sense_delay_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> sense_o == $past(sense_i, 2));
endmodule

bind outsw_guard outsw_guard_chk #(.NCH(NCH), .BLANK(BLANK_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_en_i (frame_en_i),
  .cmd_i      (cmd_i),
  .sense_i    (sense_i),
  .drive_en_o (drive_en_o),
  .sense_o    (sense_o)
);

// File: tb/outsw_guard_test.sv
module outsw_guard_test;
  localparam int unsigned NCH   = 8;
  localparam int unsigned BLANK = 24;
  localparam time CLK_PERIOD = 10ns;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           frame_en_i = 1'b0;
  logic [NCH-1:0] cmd_i = '0;
  logic [NCH-1:0] sense_i = '0;
  logic [NCH-1:0] drive_en_o;
  logic [NCH-1:0] sense_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  outsw_guard #(.NCH(NCH), .BLANK_CYCLES(BLANK)) uut (
    .clk        (clk),
    .rst        (rst),
    .frame_en_i (frame_en_i),
    .cmd_i      (cmd_i),
    .sense_i    (sense_i),
    .drive_en_o (drive_en_o),
    .sense_o    (sense_o)
  );

  // Behavioural reference: remaining blanking edges, enables, sense pipeline
  int           m_left = 0;
  bit [NCH-1:0] m_drive = '0;
  bit [NCH-1:0] m_s1 = '0;
  bit [NCH-1:0] m_s2 = '0;
  bit           m_prev = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_drive = '0;
      m_left  = 0;
    end else if (frame_en_i && !m_prev) begin
      m_drive = cmd_i;
      m_left  = BLANK;
    end else begin
      if (frame_en_i && m_left == 0) m_drive = m_drive & ~m_s2;
      if (m_left > 0) m_left = m_left - 1;
    end
    m_s2   = m_s1;
    m_s1   = sense_i;
    m_prev = frame_en_i;
  end

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 R3 R4 R5 R7 model drive", drive_en_o, m_drive);
      chk("R6 model sense", sense_o, m_s2);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrap_up;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    wrap_up();
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset off", drive_en_o, 8'h00);

    // Commit pattern A5
    cmd_i = 8'hA5; frame_en_i = 1'b1;
    cyc(1);
    chk("R2 commit", drive_en_o, 8'hA5);

    // Command change without an edge
    cmd_i = 8'hFF;
    cyc(2);
    chk("R5 cmd ignored", drive_en_o, 8'hA5);

    // Fault on channel 0 inside the window (now just after commit edge + 3)
    cyc(1);
    sense_i = 8'h01;
    cyc(BLANK - 4);
    chk("R3 blanked", drive_en_o, 8'hA5);
    cyc(2);
    chk("R3 cleared after window", drive_en_o, 8'hA4);
    chk("R8 others kept", drive_en_o & 8'hFE, 8'hA4);

    // Fault removed, channel stays off
    sense_i = 8'h00;
    cyc(5);
    chk("R5 stays off", drive_en_o, 8'hA4);

    // Sense path latency and status of off channels
    sense_i = 8'h3C;
    cyc(2);
    chk("R6 sense delay", sense_o, 8'h3C);
    cyc(1);
    chk("R8 only sensed on-channel cleared", drive_en_o, 8'h80);

    // Expired window while frame low
    sense_i = 8'h00; frame_en_i = 1'b0;
    cyc(1);
    frame_en_i = 1'b1; cmd_i = 8'h0F;
    cyc(1);
    chk("R2 second commit", drive_en_o, 8'h0F);
    frame_en_i = 1'b0;
    cyc(BLANK + 5);
    sense_i = 8'h0F;
    cyc(6);
    chk("R4 frame low holds", drive_en_o, 8'h0F);

    // Retrigger inside a running window, fault already present
    cmd_i = 8'h3F; frame_en_i = 1'b1;
    cyc(1);
    chk("R2 commit 3F", drive_en_o, 8'h3F);
    cyc(10);
    frame_en_i = 1'b0;
    cyc(1);
    frame_en_i = 1'b1;
    cyc(1);
    cyc(BLANK - 1);
    chk("R7 window restarted", drive_en_o, 8'h3F);
    cyc(2);
    chk("R7 cleared after new window", drive_en_o, 8'h30);

    // Mixed stimulus, checked by the model every clock
    for (int k = 0; k < 600; k++) begin
      if (($urandom % 8) == 0) frame_en_i = ~frame_en_i;
      if (($urandom % 4) == 0) cmd_i = NCH'($urandom);
      if (($urandom % 6) == 0) sense_i = NCH'($urandom);
      cyc(1);
    end

    // Reset in mid-operation
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    frame_en_i = 1'b0;
    cyc(1);
    chk("R1 reset mid-run", drive_en_o, 8'h00);
    cyc(3);
    wrap_up();
  end
endmodule